// File: doc/BRIEF.md
# Double-Data-Rate Byte Link Receiver with Word Verification

This receiver takes an 8-bit link that carries two bytes per cycle of its own strobe clock: one byte on the rising edge and one on the falling edge. It pushes the bytes into a small buffer that crosses from the link strobe domain into the local clock domain. On the local side it presents the bytes one per local clock cycle. A data-available qualifier is high only for real payload bytes. The local clock is expected to run at twice the link strobe rate, and the two ends are assumed to agree to within about 1000 ppm.

Payload travels as 128-bit words of 16 consecutive bytes. When verification is enabled, the transmitter sends one check byte after each word, followed by one filler byte whose value is undefined. The receiver XORs the 16 payload bytes together and compares the result with the check byte. It reports the outcome on a pass/fail flag. Neither the check byte nor the filler is ever shown as data.

Small clock mismatch appears at the output as empty-buffer slots. In those slots the qualifier is simply low, so each word may show zero, one or two extra idle slots beyond the check and filler positions. An empty buffer is treated as no data, never as an error.

Top module: `ddr_link_rx`

## Requirements
- R1: Within each strobe cycle, the byte sampled on the rising edge of `linkClk` is delivered before the byte sampled on the following falling edge.
- R2: Each payload byte is delivered exactly once, in link order, on `rxData` in a local cycle where `rxValid` is high. At most one byte is delivered per local cycle.
- R3: The clock-crossing buffer holds 16 bytes. When it is empty, `rxValid` stays low for that slot and no byte is lost or duplicated. A link slower than the local side therefore only adds idle slots.
- R4: With `verifyEn` low, every received byte is payload and words follow back to back. `verifyBad` never changes. `verifyEn` is changed only while `rst` is high.
- R5: With `verifyEn` high, the link carries 18-byte groups: 16 payload bytes, one check byte, then one filler byte. Bytes 17 and 18 of each group never raise `rxValid`, so exactly 16 valid bytes separate two consecutive check bytes.
- R6: The expected check value is the bitwise XOR of the 16 payload bytes of the word. When the check byte arrives, `verifyBad` becomes 1 if the received check byte differs from this value and 0 if it matches.
- R7: `verifyBad` changes only in the cycle after a check byte is judged. It holds its value through idle time and through the next word until that word's check byte is judged.
- R8: `rst` (asynchronous, active high) clears `rxValid` and `verifyBad` to 0, empties the buffer and restarts word framing at payload byte 0. A partially received word is discarded.
- R9: Bursts of several words are received without loss when the link strobe runs a few percent faster than half the local clock rate, within the buffer's slack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| linkClk | input | 1 | Incoming link strobe; data is valid on both edges, idle low |
| linkData | input | 8 | Incoming link byte lane |
| clk | input | 1 | Local clock, nominally twice the strobe rate |
| rst | input | 1 | Asynchronous active-high reset for both domains |
| verifyEn | input | 1 | 1 = check byte and filler follow each word |
| rxData | output | 8 | Delivered payload byte |
| rxValid | output | 1 | High for one cycle per delivered payload byte |
| verifyBad | output | 1 | Verdict of the last judged word: 1 = bad, 0 = good |

## Verification
The bound checker watches four things on every cycle. `verifyBad` moves only right after a judged check byte. Every valid output follows a buffer slot. Exactly 16 payload emissions precede each judgement. No judgement occurs with verification off. The bench's scenarios are needed for everything that depends on content and ordering across the clock crossing: edge order within a strobe cycle, exact byte streams under matched, fast and slow link rates, the XOR verdict of deliberately corrupted words, idle slots on a slow link, and the discarding of a word cut short by reset.

// File: rtl/ddr_link_rx_pkg.sv
`timescale 1ns/1ps
package ddr_link_rx_pkg;

  // Strobes issued by the framing control to the datapath each local cycle
  typedef struct packed {
    logic emit;   // present the current slot byte as payload
    logic seed;   // first payload byte of a word: restart the running XOR
    logic fold;   // later payload byte: fold into the running XOR
    logic judge;  // current slot byte is the check byte: latch verdict
  } rxStrobes_t;

  typedef enum logic [1:0] {
    FR_DATA  = 2'd0,
    FR_CHECK = 2'd1,
    FR_FILL  = 2'd2
  } frameState_t;

endpackage

// File: rtl/ddr_link_rx_sync.sv
`timescale 1ns/1ps
module ddr_link_rx_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/ddr_link_rx_fifo.sv
`timescale 1ns/1ps
module ddr_link_rx_fifo #(
  parameter int DEPTH_BYTES = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          linkClk,
  input  logic [DW-1:0] linkData,
  input  logic          clk,
  input  logic          rst,
  output logic          slotValid,
  output logic [DW-1:0] slotByte
);

  localparam int PAIRS = DEPTH_BYTES / 2;
  localparam int AW    = $clog2(PAIRS);
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // ---------------- link strobe domain ----------------
  logic [DW-1:0]   riseByte;
  logic [2*DW-1:0] mem [PAIRS];
  logic [PW-1:0]   wrBin;
  logic [PW-1:0]   wrGray;

  always_ff @(posedge linkClk or posedge rst) begin
    if (rst) riseByte <= '0;
    else     riseByte <= linkData;
  end

  always_ff @(negedge linkClk) begin
    mem[wrBin[AW-1:0]] <= {linkData, riseByte};
  end

  always_ff @(negedge linkClk or posedge rst) begin
    if (rst) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
    end
  end

  // ---------------- local clock domain ----------------
  logic [PW-1:0]   wrGraySync;
  logic [PW-1:0]   rdBin;
  logic            rdHalf;
  logic            bufEmpty;
  logic [2*DW-1:0] pairWord;

  ddr_link_rx_sync #(.W(PW), .STAGES(SYNC_STAGES)) wsync_i (
    .clk (clk),
    .rst (rst),
    .d   (wrGray),
    .q   (wrGraySync)
  );

  assign bufEmpty = (wrGraySync == toGray(rdBin));
  assign pairWord = mem[rdBin[AW-1:0]];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rdBin     <= '0;
      rdHalf    <= 1'b0;
      slotValid <= 1'b0;
      slotByte  <= '0;
    end else begin
      slotValid <= !bufEmpty;
      if (!bufEmpty) begin
        slotByte <= rdHalf ? pairWord[2*DW-1:DW] : pairWord[DW-1:0];
        rdHalf   <= ~rdHalf;
        if (rdHalf) rdBin <= rdBin + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr_link_rx_datapath.sv
`timescale 1ns/1ps
module ddr_link_rx_datapath
  import ddr_link_rx_pkg::*;
#(
  parameter int DEPTH_BYTES = 16,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          linkClk,
  input  logic [DW-1:0] linkData,
  input  rxStrobes_t    strb,
  output logic          slotValid,
  output logic [DW-1:0] rxData,
  output logic          rxValid,
  output logic          verifyBad
);

  logic [DW-1:0] slotByte;
  logic [DW-1:0] runXor;

  ddr_link_rx_fifo #(.DEPTH_BYTES(DEPTH_BYTES), .DW(DW), .SYNC_STAGES(2)) fifo_i (
    .linkClk   (linkClk),
    .linkData  (linkData),
    .clk       (clk),
    .rst       (rst),
    .slotValid (slotValid),
    .slotByte  (slotByte)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rxData    <= '0;
      rxValid   <= 1'b0;
      runXor    <= '0;
      verifyBad <= 1'b0;
    end else begin
      rxValid <= strb.emit;
      if (strb.emit)  rxData    <= slotByte;
      if (strb.seed)  runXor    <= slotByte;
      else if (strb.fold) runXor <= runXor ^ slotByte;
      if (strb.judge) verifyBad <= (slotByte != runXor);
    end
  end

endmodule

// File: rtl/ddr_link_rx_ctrl.sv
`timescale 1ns/1ps
module ddr_link_rx_ctrl
  import ddr_link_rx_pkg::*;
#(
  parameter int WORD_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       verifyEn,
  input  logic       slotValid,
  output rxStrobes_t strb
);

  localparam int CW = $clog2(WORD_BYTES);
  localparam logic [CW-1:0] LAST_IDX = CW'(WORD_BYTES - 1);

  frameState_t   state;
  logic [CW-1:0] byteIdx;

  always_comb begin
    strb = '0;
    if (slotValid) begin
      unique case (state)
        FR_DATA: begin
          strb.emit = 1'b1;
          strb.seed = (byteIdx == '0);
          strb.fold = (byteIdx != '0);
        end
        FR_CHECK: strb.judge = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state   <= FR_DATA;
      byteIdx <= '0;
    end else if (slotValid) begin
      unique case (state)
        FR_DATA: begin
          if (byteIdx == LAST_IDX) begin
            byteIdx <= '0;
            state   <= verifyEn ? FR_CHECK : FR_DATA;
          end else begin
            byteIdx <= byteIdx + 1'b1;
          end
        end
        FR_CHECK: state <= FR_FILL;
        default:  state <= FR_DATA;
      endcase
    end
  end

endmodule

// File: rtl/ddr_link_rx.sv
`timescale 1ns/1ps
module ddr_link_rx
  import ddr_link_rx_pkg::*;
#(
  parameter int DEPTH_BYTES = 16,
  parameter int WORD_BYTES  = 16,
  parameter int DW          = 8
) (
  input  logic          linkClk,
  input  logic [DW-1:0] linkData,
  input  logic          clk,
  input  logic          rst,
  input  logic          verifyEn,
  output logic [DW-1:0] rxData,
  output logic          rxValid,
  output logic          verifyBad
);

  rxStrobes_t strb;
  logic       slotValid;

  ddr_link_rx_datapath #(.DEPTH_BYTES(DEPTH_BYTES), .DW(DW)) path_i (
    .clk       (clk),
    .rst       (rst),
    .linkClk   (linkClk),
    .linkData  (linkData),
    .strb      (strb),
    .slotValid (slotValid),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .verifyBad (verifyBad)
  );

  ddr_link_rx_ctrl #(.WORD_BYTES(WORD_BYTES)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .verifyEn  (verifyEn),
    .slotValid (slotValid),
    .strb      (strb)
  );

endmodule

// File: rtl/ddr_link_rx_chk.sv
`timescale 1ns/1ps
module ddr_link_rx_chk
  import ddr_link_rx_pkg::*;
#(
  parameter int WORD_BYTES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       verifyEn,
  input logic       rxValid,
  input logic       verifyBad,
  input logic       slotValid,
  input rxStrobes_t strb
);

  logic [7:0] runCnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             runCnt <= '0;
    else if (strb.judge) runCnt <= '0;
    else if (strb.emit && runCnt != 8'hFF) runCnt <= runCnt + 1'b1;
  end

  // R7: the verdict moves only right after a check byte was judged
  p_verdict_moves_on_check_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(verifyBad) |-> $past(strb.judge));

  // R3: a valid output byte always comes from a filled buffer slot
  p_valid_from_slot_r3: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> $past(slotValid));

  // R5: exactly one word of payload precedes each judged check byte
  p_word_before_check_r5: assert property (@(posedge clk) disable iff (rst)
    strb.judge |-> (runCnt == 8'(WORD_BYTES)));

  // R4: no check byte is judged with verification off
  p_no_check_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    !verifyEn |-> !strb.judge);

endmodule

bind ddr_link_rx ddr_link_rx_chk #(.WORD_BYTES(WORD_BYTES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .verifyEn  (verifyEn),
  .rxValid   (rxValid),
  .verifyBad (verifyBad),
  .slotValid (slotValid),
  .strb      (strb)
);

// File: tb/ddr_link_rx_tb_top.sv
`timescale 1ns/1ps
module ddr_link_rx_tb_top;

  typedef struct packed {
    logic        verify;
    logic [3:0]  words;
    logic [15:0] periodPs;
    logic [3:0]  badWord;   // 4'hF = no corrupted word
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{verify:1'b0, words:4'd2, periodPs:16'd10000, badWord:4'hF},
    '{verify:1'b1, words:4'd1, periodPs:16'd10000, badWord:4'hF},
    '{verify:1'b1, words:4'd3, periodPs:16'd10000, badWord:4'd1},
    '{verify:1'b1, words:4'd3, periodPs:16'd9600,  badWord:4'd2},
    '{verify:1'b0, words:4'd3, periodPs:16'd9600,  badWord:4'hF},
    '{verify:1'b1, words:4'd2, periodPs:16'd13000, badWord:4'd1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       linkClk = 1'b0;
  logic [7:0] linkData = 8'h00;
  logic       verifyEn = 1'b0;
  logic [7:0] rxData;
  logic       rxValid;
  logic       verifyBad;

  always #2.5 clk = ~clk;

  ddr_link_rx dut_i (
    .linkClk   (linkClk),
    .linkData  (linkData),
    .clk       (clk),
    .rst       (rst),
    .verifyEn  (verifyEn),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .verifyBad (verifyBad)
  );

  int nChecks = 0;
  int nFail   = 0;

  // receive monitor
  logic [7:0] got [256];
  logic       verdictLog [16];
  int rcvCount = 0;
  int cyc = 0;
  int firstCyc = -1;
  int lastCyc  = -1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      rcvCount = 0;
      firstCyc = -1;
      lastCyc  = -1;
    end else if (rxValid) begin
      if (rcvCount > 0 && rcvCount % 16 == 0 && rcvCount / 16 <= 16)
        verdictLog[rcvCount/16 - 1] = verifyBad;
      if (rcvCount < 256) got[rcvCount] = rxData;
      if (firstCyc < 0) firstCyc = cyc;
      lastCyc  = cyc;
      rcvCount = rcvCount + 1;
    end
  end

  // transmit side
  logic [7:0] txBuf [256];
  logic [7:0] expBuf [256];
  logic       expVerdict [16];
  int txLen = 0;
  int expLen = 0;

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  task automatic sendPair(input logic [7:0] lo, input logic [7:0] hi, input realtime q);
    linkData = lo;
    #(q) linkClk = 1'b1;
    #(q) linkData = hi;
    #(q) linkClk = 1'b0;
    #(q);
  endtask

  task automatic sendBuf(input int periodPs);
    realtime q;
    q = periodPs / 4000.0;
    for (int i = 0; i < txLen; i += 2) sendPair(txBuf[i], txBuf[i+1], q);
    linkData = 8'h00;
  endtask

  task automatic buildWords(input int seed, input logic verify, input int words, input int badWord);
    logic [7:0] x;
    logic [7:0] b;
    txLen  = 0;
    expLen = 0;
    for (int w = 0; w < words; w++) begin
      x = 8'h00;
      for (int k = 0; k < 16; k++) begin
        b = 8'((expLen * 37 + seed * 11 + 5) & 255);
        x = x ^ b;
        txBuf[txLen]   = b;
        expBuf[expLen] = b;
        txLen++;
        expLen++;
      end
      expVerdict[w] = (w == badWord);
      if (verify) begin
        txBuf[txLen] = (w == badWord) ? (x ^ 8'h5A) : x;
        txLen++;
        txBuf[txLen] = 8'hC3;   // filler
        txLen++;
      end
    end
  endtask

  task automatic doReset(input logic ven);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    verifyEn = ven;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic int firstMismatch();
    for (int i = 0; i < expLen; i++)
      if (i >= rcvCount || got[i] !== expBuf[i]) return i;
    return -1;
  endfunction

  initial begin
    #500000;
    nFail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    #1 rst = 1'b1;
    doReset(1'b0);

    // R8: reset state
    checkVal("R8", "rxValid after reset", int'(rxValid), 0);
    checkVal("R8", "verifyBad after reset", int'(verifyBad), 0);

    // R1: rising-edge byte precedes falling-edge byte
    sendPair(8'hA1, 8'hB2, 2.5);
    repeat (20) @(negedge clk);
    checkVal("R1", "byte count for one pair", rcvCount, 2);
    checkVal("R1", "first byte (rising edge)", int'(got[0]), 'hA1);
    checkVal("R1", "second byte (falling edge)", int'(got[1]), 'hB2);

    // table of scenarios
    for (int vi = 0; vi < NVEC; vi++) begin
      doReset(VECS[vi].verify);
      buildWords(vi, VECS[vi].verify, int'(VECS[vi].words), int'(VECS[vi].badWord));
      sendBuf(int'(VECS[vi].periodPs));
      repeat (60) @(negedge clk);
      if (VECS[vi].verify) begin
        checkVal("R5", $sformatf("vec%0d payload count", vi), rcvCount, expLen);
        checkVal("R2", $sformatf("vec%0d first mismatch index", vi), firstMismatch(), -1);
        for (int w = 0; w + 1 < int'(VECS[vi].words); w++)
          checkVal("R6", $sformatf("vec%0d verdict word %0d", vi, w),
                   int'(verdictLog[w]), int'(expVerdict[w]));
        checkVal("R6", $sformatf("vec%0d verdict last word", vi),
                 int'(verifyBad), int'(expVerdict[int'(VECS[vi].words) - 1]));
      end else begin
        checkVal("R4", $sformatf("vec%0d payload count", vi), rcvCount, expLen);
        checkVal("R4", $sformatf("vec%0d first mismatch index", vi), firstMismatch(), -1);
        checkVal("R4", $sformatf("vec%0d verdict unchanged", vi), int'(verifyBad), 0);
      end
      if (VECS[vi].periodPs < 16'd10000)
        checkVal("R9", $sformatf("vec%0d fast-link byte count", vi), rcvCount, expLen);
    end

    // R7: last word of the final vector was bad; verdict holds through idle
    repeat (50) @(negedge clk);
    checkVal("R7", "verdict held in idle", int'(verifyBad), 1);
    doReset(1'b1);
    checkVal("R8", "verdict cleared by reset", int'(verifyBad), 0);

    // R3: slow link yields idle slots but no loss
    doReset(1'b0);
    buildWords(20, 1'b0, 1, 15);
    sendBuf(13000);
    repeat (40) @(negedge clk);
    checkVal("R3", "slow-link byte count", rcvCount, 16);
    checkVal("R3", "slow-link first mismatch index", firstMismatch(), -1);
    checkVal("R3", "idle slots inside word present",
             ((lastCyc - firstCyc + 1 - rcvCount) > 0) ? 1 : 0, 1);

    // R8: word cut short by reset is discarded, framing restarts
    doReset(1'b1);
    for (int i = 0; i < 5; i++) sendPair(8'(i), 8'(i + 100), 2.5);
    repeat (10) @(negedge clk);
    doReset(1'b1);
    buildWords(30, 1'b1, 1, 15);
    sendBuf(10000);
    repeat (40) @(negedge clk);
    checkVal("R8", "count after mid-word reset", rcvCount, 16);
    checkVal("R8", "stream after mid-word reset", firstMismatch(), -1);
    checkVal("R6", "verdict after mid-word reset", int'(verifyBad), 0);

    report();
    $finish;
  end

endmodule